// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Unit

This block sits beside a real-time clock's timekeeping core. It holds three alarm bytes, one each for seconds, minutes and hours. When the core reports that a time update has finished, the block compares the current time fields with those alarm bytes. An alarm byte whose two top bits are both set acts as a wildcard and matches any value of its field.

The block also keeps the interrupt flag register. This register records periodic, alarm and update-finished events. A summary bit in it is high when any recorded event also has its enable set in the control register, which the block receives as an input. An active-low interrupt line follows that summary bit.

A host reads the register file through a simple address and read strobe. It writes alarm bytes with a write strobe. Reading the flag register clears every flag in the same access.

Top module: `alarm_flag_unit`

## Requirements
- R1: Alarm bytes for seconds, minutes and hours are written and read back at addresses 1, 3 and 5. Reads of addresses 0, 2 and 4 return the current seconds, minutes and hours inputs. `rdata` is combinational and is 0 whenever `rd_en` is low.
- R2: An alarm byte with bits 7 and 6 both 1 matches any time value. Any other alarm byte matches only an equal value, so 0x80 is not a wildcard.
- R3: The alarm flag is set in the cycle after an `upd_done` pulse, and only when all three fields match or are wildcards. Without `upd_done`, a match sets nothing.
- R4: A `per_pulse` sets the periodic flag. An `upd_done` pulse sets the update flag. A read of address 12 returns the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3..0 of that read are 0.
- R5: Flags are set whatever the state of their enables, and they stay set until address 12 is read.
- R6: Bit 7 of the flag read is 1 exactly when some flag is set and its enable is set. The enables are `ctrl_reg` bit 6 (periodic), bit 5 (alarm) and bit 4 (update).
- R7: A read of address 12 returns the flag value held before the read. All flags are clear in the next cycle.
- R8: An event that arrives in the same cycle as a read of address 12 is not lost. Its flag is set after the read.
- R9: `irq_n` is the inverse of the flag summary bit, so it is low while an enabled flag is set.
- R10: After reset, all alarm bytes and flags are 0 and `irq_n` is 1.
- R11: Reads of unmapped addresses return 0. Writes to addresses other than 1, 3 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| cur_sec | input | 8 | Current seconds value |
| cur_min | input | 8 | Current minutes value |
| cur_hour | input | 8 | Current hours value |
| ctrl_reg | input | 8 | Control register, bits 6..4 are the enables |
| upd_done | input | 1 | Time update finished pulse |
| per_pulse | input | 1 | Periodic event pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The alarm compare is tried with exact matches, with a single mismatching field, with a match that arrives without an update pulse, and with wildcard bytes (0xC0 and 0xFF) beside a non-wildcard 0x80. These cases separate the gating by the update pulse, the need for all three fields to agree, and the two-top-bit wildcard test.

The flag logic is driven with events under all-zero and selected enables. This shows that flags are recorded whether or not they are enabled, while only the summary bit and the interrupt line follow the enables. A read that coincides with a new event shows that the returned value is the old one and that the new flag survives the clear.

// File: rtl/alarm_flag_unit.sv
module alarm_flag_unit #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] ctrl_reg,
  input  logic          upd_done,
  input  logic          per_pulse,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_SEC   = AW'(0);
  localparam logic [AW-1:0] A_ASEC  = AW'(1);
  localparam logic [AW-1:0] A_MIN   = AW'(2);
  localparam logic [AW-1:0] A_AMIN  = AW'(3);
  localparam logic [AW-1:0] A_HOUR  = AW'(4);
  localparam logic [AW-1:0] A_AHOUR = AW'(5);
  localparam logic [AW-1:0] A_FLAGS = AW'(12);

  logic [DW-1:0] alm_s, alm_m, alm_h;
  logic pf_q, af_q, uf_q;

  function automatic logic field_hit(input logic [DW-1:0] a, input logic [DW-1:0] t);
    return (&a[DW-1:DW-2]) || (a == t);
  endfunction

  wire alarm_ev = upd_done && field_hit(alm_s, cur_sec)
                           && field_hit(alm_m, cur_min)
                           && field_hit(alm_h, cur_hour);
  wire flag_rd  = rd_en && (addr == A_FLAGS);
  wire irq_req  = (pf_q && ctrl_reg[6]) || (af_q && ctrl_reg[5]) || (uf_q && ctrl_reg[4]);

  assign irq_n = ~irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_s <= '0;
      alm_m <= '0;
      alm_h <= '0;
    end else if (wr_en) begin
      case (addr)
        A_ASEC:  alm_s <= wdata;
        A_AMIN:  alm_m <= wdata;
        A_AHOUR: alm_h <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else if (flag_rd) begin
      pf_q <= per_pulse;
      af_q <= alarm_ev;
      uf_q <= upd_done;
    end else begin
      pf_q <= pf_q | per_pulse;
      af_q <= af_q | alarm_ev;
      uf_q <= uf_q | upd_done;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_SEC:   rdata = cur_sec;
        A_ASEC:  rdata = alm_s;
        A_MIN:   rdata = cur_min;
        A_AMIN:  rdata = alm_m;
        A_HOUR:  rdata = cur_hour;
        A_AHOUR: rdata = alm_h;
        A_FLAGS: rdata = DW'({irq_req, pf_q, af_q, uf_q, 4'b0000});
        default: rdata = '0;
      endcase
    end
  end
endmodule

module alarm_flag_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          upd_done,
  input logic          per_pulse,
  input logic          pf_q,
  input logic          af_q,
  input logic          uf_q,
  input logic [DW-1:0] rdata,
  input logic          irq_n
);
  wire flag_rd = rd_en && (addr == AW'(12));

  assert_pf_set_R4: assert property (@(posedge clk) disable iff (!rst_n) per_pulse |=> pf_q);
  assert_uf_set_R4: assert property (@(posedge clk) disable iff (!rst_n) upd_done |=> uf_q);
  assert_af_needs_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af_q) |-> $past(upd_done));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !per_pulse && !upd_done) |=> (!pf_q && !af_q && !uf_q));
  assert_event_survives_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && per_pulse) |=> pf_q);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (af_q && !flag_rd) |=> af_q);
  assert_irq_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |-> (irq_n == !rdata[7]));
endmodule

bind alarm_flag_unit alarm_flag_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .upd_done(upd_done),
  .per_pulse(per_pulse), .pf_q(pf_q), .af_q(af_q), .uf_q(uf_q),
  .rdata(rdata), .irq_n(irq_n)
);

// File: tb/test_alarm_flag_unit.sv
module test_alarm_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0, upd_done = 1'b0, per_pulse = 1'b0;
  logic [7:0] wdata = '0, cur_sec = '0, cur_min = '0, cur_hour = '0, ctrl_reg = '0;
  logic [7:0] rdata;
  logic irq_n;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  int m_alm[3];
  bit m_pf, m_af, m_uf;

  always #10 clk = ~clk;

  alarm_flag_unit i_alarm_flag_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .ctrl_reg(ctrl_reg), .upd_done(upd_done),
    .per_pulse(per_pulse), .irq_n(irq_n)
  );

  function automatic bit hit(int a, int t);
    return (a >= 8'hC0) || (a == t);
  endfunction

  function automatic bit summary();
    return (m_pf && ctrl_reg[6]) || (m_af && ctrl_reg[5]) || (m_uf && ctrl_reg[4]);
  endfunction

  function automatic int exp_rdata();
    if (!rd_en) return 0;
    case (addr)
      0: return cur_sec;
      1: return m_alm[0];
      2: return cur_min;
      3: return m_alm[1];
      4: return cur_hour;
      5: return m_alm[2];
      12: return summary()*128 + m_pf*64 + m_af*32 + m_uf*16;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    bit ev_a;
    #1;
    chk(cur_req, rdata, exp_rdata());
    chk({cur_req, " R9 irq_n"}, irq_n, !summary());
    ev_a = upd_done && hit(m_alm[0], cur_sec) && hit(m_alm[1], cur_min) && hit(m_alm[2], cur_hour);
    @(posedge clk);
    if (rst_n) begin
      if (rd_en && addr == 12) begin
        m_pf = per_pulse; m_af = ev_a; m_uf = upd_done;
      end else begin
        m_pf |= per_pulse; m_af |= ev_a; m_uf |= upd_done;
      end
      if (wr_en && addr inside {1, 3, 5}) m_alm[addr/2] = wdata;
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0; upd_done = 0; per_pulse = 0;
  endtask

  task automatic wr(int a, int d);
    addr = 4'(a); wdata = 8'(d); wr_en = 1; step();
  endtask

  task automatic rd(int a);
    addr = 4'(a); rd_en = 1; step();
  endtask

  task automatic update();
    upd_done = 1; step();
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cur_req = "R10";
    chk("R10 irq_n after reset", irq_n, 1);
    rd(12); rd(1); rd(3); rd(5);

    cur_req = "R1";
    wr(1, 8'h12); wr(3, 8'h34); wr(5, 8'h56);
    cur_sec = 8'h59; cur_min = 8'h07; cur_hour = 8'h23;
    rd(0); rd(1); rd(2); rd(3); rd(4); rd(5);
    addr = 4'd1;
    #1;
    chk("R1 rdata zero without rd_en", rdata, 0);
    @(negedge clk);

    cur_req = "R11";
    wr(7, 8'hAA); wr(12, 8'hFF); wr(0, 8'h11);
    rd(7); rd(13); rd(15); rd(12); rd(1); rd(0);

    cur_req = "R5";
    ctrl_reg = 8'h00;
    per_pulse = 1; step();
    step(); step();
    cur_req = "R7";
    addr = 4'd12; rd_en = 1;
    #1;
    chk("R7 read returns old flags", rdata, 8'h40);
    step();
    rd(12);

    cur_req = "R6";
    ctrl_reg = 8'h40;
    per_pulse = 1; step();
    chk("R9 irq low when enabled flag set", irq_n, 0);
    ctrl_reg = 8'h30; step();
    ctrl_reg = 8'h70; rd(12);

    cur_req = "R3";
    ctrl_reg = 8'h20;
    cur_sec = 8'h12; cur_min = 8'h34; cur_hour = 8'h56;
    step();
    addr = 4'd12; rd_en = 1; step();
    update();
    rd(12);
    cur_min = 8'h35; update(); rd(12);
    cur_min = 8'h34; step(); step(); rd(12);

    cur_req = "R2";
    wr(5, 8'hC0); wr(3, 8'hFF);
    cur_hour = 8'h01; cur_min = 8'h42; update(); rd(12);
    wr(1, 8'h80); cur_sec = 8'h00; update(); rd(12);
    cur_sec = 8'h80; update(); rd(12);

    cur_req = "R8";
    ctrl_reg = 8'h70;
    per_pulse = 1; step();
    addr = 4'd12; rd_en = 1; upd_done = 1; per_pulse = 1; step();
    rd(12); rd(12);

    cur_req = "R4";
    upd_done = 1; step(); rd(12);
    per_pulse = 1; step(); rd(12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule